// File: doc/BRIEF.md
# Serial Transmitter Sharing a Port Pin

This block serialises bytes into asynchronous frames. Each frame has a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Every bit is held for a parameterised number of ticks of an oversampling enable that a baud generator outside the block supplies. A one-byte holding register sits in front of the shift register, so the next byte can be written while the current frame is still on the line.

The output pin is shared with a general-purpose port bit, which has its own level and direction inputs. While the transmitter is disabled, the pin is an ordinary port driven straight from those two bits. Dropping the enable abandons any frame at once and returns the pin to the port. Software uses this to hold the line low as a break: it clears the port level, keeps the direction as output, and then clears the enable.

A hold input makes the block wait while any of the three receive error flags is raised. A written byte stays parked until the flags clear.

Top module: `sertx_port_tx`

## Requirements
- R1: While `tx_en_i` is 0, `pin_o` equals `port_dat_i` and `pin_oe_o` equals `port_dir_i`, combinationally and in every cycle.
- R2: After reset, and on the clock edge after any cycle with `tx_en_i` at 0, both `tx_empty_o` and `tx_end_o` are 1. Writes made while `tx_en_i` is 0 are discarded: after the block is enabled, no frame is sent and `tx_empty_o` stays 1.
- R3: While `tx_en_i` is 1 and no frame is in progress, `pin_oe_o` is 1 and `pin_o` is 1 (mark level).
- R4: A frame is sent in this order: a start bit of 0, then DATA_W data bits with bit 0 first, then a parity bit if `par_en_i` is 1, then a stop bit of 1. With `par_odd_i` at 0 the parity bit makes the count of ones in data plus parity even; with `par_odd_i` at 1 it makes the count odd. Each bit lasts OVS ticks of `tick_i`, default 16.
- R5: A `wr_stb_i` pulse while enabled sets `tx_empty_o` to 0 on the next edge. When the block is idle, the following edge copies the byte into the shift register. On that same edge `tx_empty_o` returns to 1, `tx_end_o` falls to 0, and `pin_o` goes low.
- R6: When `hold_on_err_i` is 1 and any of `rx_ovr_err_i`, `rx_par_err_i` or `rx_frm_err_i` is 1, no frame starts. The waiting byte is sent on the edge after the flags clear. When `hold_on_err_i` is 0, the flags have no effect.
- R7: On the edge that ends a stop bit, `tx_end_o` becomes 1 if no byte is waiting. If a byte is waiting, `tx_end_o` stays 0 and the next frame begins one clock later.
- R8: Clearing `tx_en_i` in the middle of a frame hands the pin to the port in the same cycle, so port level 0 with direction 1 drives a continuous break. When the block is enabled again, the line idles high and no part of the old frame resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling enable, one pulse per tick |
| tx_en_i | input | 1 | Transmitter enable; 0 gives the pin to the port |
| wr_stb_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| par_en_i | input | 1 | Parity bit included when 1 |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| hold_on_err_i | input | 1 | Block frame starts while a receive error is flagged |
| rx_ovr_err_i | input | 1 | Receive overrun flag |
| rx_par_err_i | input | 1 | Receive parity flag |
| rx_frm_err_i | input | 1 | Receive framing flag |
| port_dat_i | input | 1 | Port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_o | output | 1 | Pin level |
| pin_oe_o | output | 1 | Pin drive enable |
| tx_empty_o | output | 1 | Holding register empty |
| tx_end_o | output | 1 | Transmission finished, line idle |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and OVS = 16. This makes the sampled bit centre fall on tick 8 of each 16-tick bit, and it makes the parity position follow the eighth data bit. Ticks arrive at random gaps, so both the bit length and the back-to-back gap between frames are measured in ticks and not in clocks. Random bytes are sent both with and without parity, and with both parity senses. Directed runs cover a byte written during a frame, a start parked by error flags, an abort in the middle of a frame that turns into a break, and writes made while the transmitter is disabled.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/sertx_bitclk.sv
`timescale 1ns/1ps
// Counts oversampling ticks within one bit and flags the last one.
module sertx_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_done_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (run_i && tick_i)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_done_o = run_i && tick_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/sertx_frame.sv
`timescale 1ns/1ps
// Holding register, shift register and frame sequencer.
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              start_ok_i,
  input  logic              bit_done_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              line_o,
  output logic              tx_empty_o,
  output logic              tx_end_o
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] dbuf_q, dbuf_d;
  logic              par_q, par_d;
  logic              empty_q, empty_d;
  logic              end_q, end_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    dbuf_d  = dbuf_q;
    par_d   = par_q;
    empty_d = empty_q;
    end_d   = end_q;
    load_o  = 1'b0;
    if (!tx_en_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      empty_d = 1'b1;
      end_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!empty_q && start_ok_i) begin
            load_o  = 1'b1;
            state_d = ST_START;
            shreg_d = dbuf_q;
            par_d   = (^dbuf_q) ^ par_odd_i;
            empty_d = 1'b1;
            end_d   = 1'b0;
          end
        end
        ST_START: begin
          if (bit_done_i) begin
            state_d = ST_DATA;
            idx_d   = '0;
          end
        end
        ST_DATA: begin
          if (bit_done_i) begin
            shreg_d = shreg_q >> 1;
            if (idx_q == LAST_IDX) state_d = par_en_i ? ST_PAR : ST_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_done_i) state_d = ST_STOP;
        end
        ST_STOP: begin
          if (bit_done_i) begin
            state_d = ST_IDLE;
            end_d   = empty_q && !wr_stb_i;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (wr_stb_i) begin
        dbuf_d  = wr_data_i;
        empty_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      dbuf_q  <= '0;
      par_q   <= 1'b0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      dbuf_q  <= dbuf_d;
      par_q   <= par_d;
      empty_q <= empty_d;
      end_q   <= end_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign tx_empty_o = empty_q;
  assign tx_end_o   = end_q;
endmodule

// File: rtl/sertx_pinmux.sv
`timescale 1ns/1ps
// Selects between the serial line and the general-purpose port.
module sertx_pinmux (
  input  logic tx_en_i,
  input  logic line_i,
  input  logic port_dat_i,
  input  logic port_dir_i,
  output logic pin_o,
  output logic pin_oe_o
);
  always_comb begin
    if (tx_en_i) begin
      pin_o    = line_i;
      pin_oe_o = 1'b1;
    end else begin
      pin_o    = port_dat_i;
      pin_oe_o = port_dir_i;
    end
  end
endmodule

// File: rtl/sertx_port_tx.sv
`timescale 1ns/1ps
module sertx_port_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              hold_on_err_i,
  input  logic              rx_ovr_err_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              port_dat_i,
  input  logic              port_dir_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              tx_empty_o,
  output logic              tx_end_o
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       start_ok, load, busy, bit_done, line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign start_ok = !(hold_on_err_i && (rx_ovr_err_i || rx_par_err_i || rx_frm_err_i));

  sertx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(load || !tx_en_i),
    .run_i(busy), .tick_i(tick_i), .bit_done_o(bit_done)
  );

  sertx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .tx_en_i(tx_en_i), .wr_stb_i(wr_stb_i),
    .wr_data_i(wr_data_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .start_ok_i(start_ok), .bit_done_i(bit_done), .load_o(load),
    .busy_o(busy), .line_o(line), .tx_empty_o(tx_empty_o), .tx_end_o(tx_end_o)
  );

  sertx_pinmux u_pinmux (
    .tx_en_i(tx_en_i), .line_i(line), .port_dat_i(port_dat_i),
    .port_dir_i(port_dir_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );
endmodule

// File: rtl/sertx_port_tx_chk.sv
`timescale 1ns/1ps
module sertx_port_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en_i,
  input logic wr_stb_i,
  input logic hold_on_err_i,
  input logic rx_ovr_err_i,
  input logic rx_par_err_i,
  input logic rx_frm_err_i,
  input logic port_dat_i,
  input logic port_dir_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic tx_empty_o,
  input logic tx_end_o
);
  // R1: port owns the pin while disabled
  p_port_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> (pin_o == port_dat_i) && (pin_oe_o == port_dir_i));

  // R2: flags return to their idle values after a disabled cycle
  p_flags_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> tx_empty_o && tx_end_o);

  // R3: finished and enabled means driving mark
  p_mark_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i && tx_end_o |-> pin_o && pin_oe_o);

  // R4/R5: a frame begins with a low start bit
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i && $fell(tx_end_o) |-> !pin_o && tx_empty_o);

  // R5: a write while enabled fills the holding register
  p_write_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i && wr_stb_i |=> !tx_empty_o);

  // R6: raised error flags keep an idle transmitter idle
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i && hold_on_err_i && (rx_ovr_err_i || rx_par_err_i || rx_frm_err_i)
      && tx_end_o |=> tx_end_o);
endmodule

bind sertx_port_tx sertx_port_tx_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_en_i(tx_en_i), .wr_stb_i(wr_stb_i),
  .hold_on_err_i(hold_on_err_i), .rx_ovr_err_i(rx_ovr_err_i),
  .rx_par_err_i(rx_par_err_i), .rx_frm_err_i(rx_frm_err_i),
  .port_dat_i(port_dat_i), .port_dir_i(port_dir_i), .pin_o(pin_o),
  .pin_oe_o(pin_oe_o), .tx_empty_o(tx_empty_o), .tx_end_o(tx_end_o)
);

// File: tb/sertx_port_tx_bench.sv
`timescale 1ns/1ps
module sertx_port_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick, tx_en, wr_stb, par_en, par_odd, hold;
  logic       e_ovr, e_par, e_frm, pdat, pdir;
  logic [7:0] wr_data;
  logic       pin, pin_oe, tx_empty, tx_end;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  sertx_port_tx u_sertx_port_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tx_en_i(tx_en),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data), .par_en_i(par_en),
    .par_odd_i(par_odd), .hold_on_err_i(hold), .rx_ovr_err_i(e_ovr),
    .rx_par_err_i(e_par), .rx_frm_err_i(e_frm), .port_dat_i(pdat),
    .port_dir_i(pdir), .pin_o(pin), .pin_oe_o(pin_oe),
    .tx_empty_o(tx_empty), .tx_end_o(tx_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit t);
    tick = t;
    @(negedge clk);
  endtask

  function automatic bit exp_bit(input logic [7:0] d, input bit pe, input bit po, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9 && pe) return (^d) ^ po;
    return 1'b1;
  endfunction

  // write a byte while idle; expect the frame to start two edges later
  task automatic start_frame(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    step(0);
    wr_stb = 1'b0;
    chk(tx_empty == 1'b0, "R5 empty cleared by write", tx_empty, 0);
    step(0);
    chk(pin == 1'b0 && tx_empty == 1'b1 && tx_end == 1'b0,
        "R5 load starts frame", {pin, tx_empty, tx_end}, 3'b010);
  endtask

  // frame has just started; sample each bit centre, optionally queue a next byte
  task automatic run_frame(input logic [7:0] d, input bit pe, input bit po,
                           input bit wr_next, input logic [7:0] nd);
    int nb = pe ? 11 : 10;
    int n  = 0;
    for (int k = 0; k < nb; k++) begin
      while (n < 8 + 16 * k) begin
        bit t = 1'($urandom_range(0, 1));
        step(t);
        n += int'(t);
      end
      chk(pin == exp_bit(d, pe, po, k), "R4 frame bit", pin, exp_bit(d, pe, po, k));
      if (wr_next && k == 2) begin
        wr_data = nd; wr_stb = 1'b1;
        step(0);
        wr_stb = 1'b0;
      end
    end
    while (n < 16 * nb) begin
      bit t = 1'($urandom_range(0, 1));
      step(t);
      n += int'(t);
    end
    chk(tx_end == !wr_next, "R7 end flag after stop bit", tx_end, !wr_next);
    if (wr_next) begin
      chk(pin == 1'b1, "R7 one idle clock between frames", pin, 1);
      step(0);
      chk(pin == 1'b0 && tx_empty == 1'b1, "R7 back-to-back start", {pin, tx_empty}, 2'b01);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    rst_n = 1'b0; tick = 1'b0; tx_en = 1'b0; wr_stb = 1'b0; wr_data = '0;
    par_en = 1'b0; par_odd = 1'b0; hold = 1'b0;
    e_ovr = 1'b0; e_par = 1'b0; e_frm = 1'b0; pdat = 1'b1; pdir = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_empty && tx_end, "R2 reset state flags", {tx_empty, tx_end}, 2'b11);
    rst_n = 1'b1;
    repeat (4) step(0);

    // R1: port patterns while disabled
    for (int i = 0; i < 4; i++) begin
      pdat = i[0]; pdir = i[1];
      #0.5;
      chk(pin == pdat && pin_oe == pdir, "R1 port mode", {pin, pin_oe}, {pdat, pdir});
      step(0);
    end

    // R2: write while disabled is discarded
    pdat = 1'b1; pdir = 1'b1;
    wr_data = 8'hA5; wr_stb = 1'b1; step(0); wr_stb = 1'b0;
    tx_en = 1'b1;
    for (int i = 0; i < 40; i++) step(1);
    chk(pin == 1'b1 && tx_empty == 1'b1, "R2 disabled write ignored", {pin, tx_empty}, 2'b11);
    chk(pin_oe == 1'b1 && tx_end == 1'b1, "R3 idle mark driven", {pin_oe, tx_end}, 2'b11);

    // R4: directed corner bytes in each parity mode
    start_frame(8'h00); run_frame(8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    par_en = 1'b1; par_odd = 1'b1;
    start_frame(8'hFF); run_frame(8'hFF, 1'b1, 1'b1, 1'b0, 8'h00);
    par_odd = 1'b0;
    start_frame(8'h01); run_frame(8'h01, 1'b1, 1'b0, 1'b0, 8'h00);

    // R7: back-to-back frames
    par_en = 1'b0;
    start_frame(8'h3C); run_frame(8'h3C, 1'b0, 1'b0, 1'b1, 8'hC3);
    run_frame(8'hC3, 1'b0, 1'b0, 1'b0, 8'h00);

    // R6: error hold blocks start, then releases
    hold = 1'b1; e_par = 1'b1;
    wr_data = 8'h5A; wr_stb = 1'b1; step(0); wr_stb = 1'b0;
    for (int i = 0; i < 40; i++) step(1);
    chk(pin == 1'b1 && tx_end == 1'b1 && tx_empty == 1'b0, "R6 start blocked by error",
        {pin, tx_end, tx_empty}, 3'b110);
    e_par = 1'b0; e_frm = 1'b1; step(1);
    chk(tx_end == 1'b1, "R6 framing flag also blocks", tx_end, 1);
    e_frm = 1'b0; step(0);
    chk(pin == 1'b0 && tx_end == 1'b0, "R6 start after flags clear", {pin, tx_end}, 2'b00);
    run_frame(8'h5A, 1'b0, 1'b0, 1'b0, 8'h00);
    hold = 1'b0; e_ovr = 1'b1;
    start_frame(8'h96); run_frame(8'h96, 1'b0, 1'b0, 1'b0, 8'h00);
    e_ovr = 1'b0;

    // R8: abort mid-frame into a break, then clean restart
    start_frame(8'hFF);
    for (int i = 0; i < 40; i++) step(1);
    pdat = 1'b0; pdir = 1'b1; tx_en = 1'b0;
    #0.5;
    chk(pin == 1'b0 && pin_oe == 1'b1, "R8 break immediate", {pin, pin_oe}, 2'b01);
    step(1);
    for (int i = 0; i < 20; i++) step(1);
    chk(pin == 1'b0, "R8 break held", pin, 0);
    chk(tx_empty && tx_end, "R2 flags after abort", {tx_empty, tx_end}, 2'b11);
    pdat = 1'b1; tx_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (pin != 1'b1) begin
        chk(1'b0, "R8 no frame resumes", pin, 1);
        break;
      end
    end
    chk(pin == 1'b1 && tx_end == 1'b1, "R8 idle after re-enable", {pin, tx_end}, 2'b11);

    // R4/R7: random traffic
    for (int f = 0; f < 20; f++) begin
      logic [7:0] d = 8'($urandom);
      bit pe = 1'($urandom_range(0, 1));
      bit po = 1'($urandom_range(0, 1));
      bit bb = 1'($urandom_range(0, 1));
      logic [7:0] d2 = 8'($urandom);
      par_en = pe; par_odd = po;
      start_frame(d);
      run_frame(d, pe, po, bb, d2);
      if (bb) run_frame(d2, pe, po, 1'b0, 8'h00);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule